// File: doc/BRIEF.md
# Prescaled Timer-Counter with Buffered Wide Access

This peripheral counts events on an 8-bit register bus. In timer mode it counts a one-clock tick pulse that marks each instruction cycle. In counter mode it counts a chosen edge of an external pin, after that pin has passed through a two-stage synchronizer. A power-of-two prescaler can sit between the event source and the counter, or it can be bypassed. The counter is either 8 or 16 bits wide. When it wraps, a sticky interrupt flag is set.

In 16-bit mode software never reaches the upper byte directly. A read of the low byte copies the live upper byte into a holding register, so a later read of the holding register gives a consistent 16-bit value. A write to the low byte loads the holding register into the upper byte, so all 16 bits change together. Every write to the low byte freezes counting for the next two instruction-cycle ticks and empties the prescaler.

Register selects: 0 is control, 1 is the low byte, 2 is the high-byte holding register, and 3 is the flag (bit 0 reads the flag; writing 1 to bit 0 clears it).

Top module: `prescaled_timer`

## Requirements
- R1: After a synchronous reset, control reads 0xA7, the count reads 0 and the flag is 0. Control bits: [7] enable, [6] wide (1 = 16-bit), [5] source (1 = external pin), [4] edge (1 = falling), [3] prescaler bypass, [2:0] ratio select.
- R2: With the source bit at 0, each tick_i pulse is one event and the pin is ignored. With the source bit at 1, tick_i does not count.
- R3: In pin mode, the edge bit picks rising (0) or falling (1) edges only. A pin change increments the count no sooner than three clock edges after it is applied.
- R4: With bypass at 0, one counter step happens per 2^(sel+1) events. With bypass at 1, each event is one step.
- R5: With the enable bit at 0, the count does not change.
- R6: A write to the low byte blocks the next two ticks' events and clears the prescaler's partial count.
- R7: In 16-bit mode, a read of the low byte copies the live upper byte into the holding register. The holding register does not change otherwise, except through a write to it.
- R8: A write to the holding register leaves the count untouched. A following low-byte write in 16-bit mode loads both bytes.
- R9: A wrap from 0xFF (8-bit mode) or 0xFFFF (16-bit mode) sets the flag. In 8-bit mode the upper byte never counts.
- R10: The flag stays set until a flag-clear write arrives. An overflow in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-clock pulse per instruction cycle |
| ext_pin_i | input | 1 | Asynchronous external count input |
| bus_addr_i | input | 2 | Register select |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| flag_o | output | 1 | Overflow interrupt flag |

## Verification
Two things can land in the same clock. A software clear of the flag can meet a counter wrap. A low-byte write can meet a counting event. The bench forces the first case by raising tick_i together with a flag-clear write while the count sits at 0xFF, and then expects the flag to stay set and the count to read 0x00. The hold-off tests write the count between ticks and judge the exact tick on which counting resumes, including the leftover prescaler phase.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic       en;
    logic       wide;
    logic       ext_src;
    logic       fall_edge;
    logic       ps_bypass;
    logic [2:0] ps_sel;
  } ptmr_ctrl_t;

  localparam logic [BYTE_W-1:0] CTRL_RESET = 8'hA7;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_LOW  = 2'd1,
    REG_HIGH = 2'd2,
    REG_FLAG = 2'd3
  } ptmr_reg_e;
endpackage

// File: rtl/ptmr_edge_sync.sv
module ptmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign cur    = sync_q[STAGES-1];
  assign edge_o = fall_sel_i ? (prev_q & ~cur) : (cur & ~prev_q);
endmodule

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             evt_i,
  input  logic             bypass_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             out_o
);
  localparam int CNT_W = 1 << SEL_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;
  logic             hit;

  // terminal value is 2^(sel+1)-1; wraps correctly at the top code
  assign mask  = (CNT_W'(2) << sel_i) - CNT_W'(1);
  assign hit   = (cnt_q & mask) == mask;
  assign out_o = bypass_i ? evt_i : (evt_i & hit);

  always_ff @(posedge clk) begin
    if (rst || clr_i || bypass_i) cnt_q <= '0;
    else if (evt_i)               cnt_q <= hit ? '0 : cnt_q + CNT_W'(1);
  end

  // R4: a divided output can never fire on two back-to-back clocks
  assert_pre_spacing_R4: assert property (@(posedge clk) disable iff (rst)
    (out_o && !bypass_i) |=> (!out_o || bypass_i));
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
  parameter int BYTE_W     = 8,
  parameter int HOLD_TICKS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_i,
  input  logic                inc_i,
  input  logic                wide_i,
  input  logic                wr_lo_i,
  input  logic [BYTE_W-1:0]   wr_lo_data_i,
  input  logic [BYTE_W-1:0]   hi_load_i,
  input  logic                clr_flag_i,
  output logic [2*BYTE_W-1:0] cnt_o,
  output logic                hold_o,
  output logic                flag_o
);
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int HOLD_W = $clog2(HOLD_TICKS + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [HOLD_W-1:0] hold_q;
  logic              flag_q;
  logic              step;
  logic              ovf;

  assign step = inc_i && (hold_q == '0) && !wr_lo_i;
  assign ovf  = step && (&cnt_q[BYTE_W-1:0]) && (!wide_i || (&cnt_q[CNT_W-1:BYTE_W]));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wr_lo_i) begin
      cnt_q[BYTE_W-1:0] <= wr_lo_data_i;
      if (wide_i) cnt_q[CNT_W-1:BYTE_W] <= hi_load_i;
    end else if (step) begin
      if (wide_i) cnt_q <= cnt_q + CNT_W'(1);
      else        cnt_q[BYTE_W-1:0] <= cnt_q[BYTE_W-1:0] + BYTE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                          hold_q <= '0;
    else if (wr_lo_i)                 hold_q <= HOLD_W'(HOLD_TICKS);
    else if (tick_i && hold_q != '0)  hold_q <= hold_q - HOLD_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)             flag_q <= 1'b0;
    else if (ovf)        flag_q <= 1'b1;
    else if (clr_flag_i) flag_q <= 1'b0;
  end

  assign cnt_o  = cnt_q;
  assign hold_o = (hold_q != '0);
  assign flag_o = flag_q;

  // R6: during hold-off the count only moves by a bus write
  assert_hold_freeze_R6: assert property (@(posedge clk) disable iff (rst)
    (hold_q != '0 && !wr_lo_i) |=> $stable(cnt_q));
  // R9: a wrap always leaves the flag set
  assert_ovf_flag_R9: assert property (@(posedge clk) disable iff (rst)
    ovf |=> flag_q);
  // R9: narrow mode never touches the upper byte
  assert_narrow_high_R9: assert property (@(posedge clk) disable iff (rst)
    (!wide_i && !wr_lo_i) |=> $stable(cnt_q[CNT_W-1:BYTE_W]));
  // R10: flag falls only through a clear request
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_flag_i) |=> flag_q);
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer #(
  parameter int PS_SEL_W    = 3,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_TICKS  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       ext_pin_i,
  input  logic [1:0] bus_addr_i,
  input  logic       bus_wr_i,
  input  logic       bus_rd_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o,
  output logic       flag_o
);
  import ptmr_pkg::*;
  localparam int CNT_W = 2 * BYTE_W;

  ptmr_ctrl_t        ctrl_q;
  logic [BYTE_W-1:0] hbuf_q;
  logic [BYTE_W-1:0] rdata_q;
  logic [CNT_W-1:0]  cnt;
  logic              ext_edge, raw_evt, gated_evt, scaled_evt, hold_act;
  logic              wr_ctrl, wr_lo, wr_hi, wr_flag, rd_lo, clr_flag;

  assign wr_ctrl  = bus_wr_i && (bus_addr_i == REG_CTRL);
  assign wr_lo    = bus_wr_i && (bus_addr_i == REG_LOW);
  assign wr_hi    = bus_wr_i && (bus_addr_i == REG_HIGH);
  assign wr_flag  = bus_wr_i && (bus_addr_i == REG_FLAG);
  assign rd_lo    = bus_rd_i && (bus_addr_i == REG_LOW);
  assign clr_flag = wr_flag && bus_wdata_i[0];

  ptmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i(ext_pin_i),
    .fall_sel_i(ctrl_q.fall_edge), .edge_o(ext_edge));

  assign raw_evt   = ctrl_q.ext_src ? ext_edge : tick_i;
  assign gated_evt = raw_evt && ctrl_q.en && !hold_act;

  ptmr_prescaler #(.SEL_W(PS_SEL_W)) u_pre (
    .clk(clk), .rst(rst), .clr_i(wr_lo), .evt_i(gated_evt),
    .bypass_i(ctrl_q.ps_bypass), .sel_i(ctrl_q.ps_sel), .out_o(scaled_evt));

  ptmr_counter #(.BYTE_W(BYTE_W), .HOLD_TICKS(HOLD_TICKS)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick_i), .inc_i(scaled_evt),
    .wide_i(ctrl_q.wide), .wr_lo_i(wr_lo), .wr_lo_data_i(bus_wdata_i),
    .hi_load_i(hbuf_q), .clr_flag_i(clr_flag), .cnt_o(cnt),
    .hold_o(hold_act), .flag_o(flag_o));

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= ptmr_ctrl_t'(CTRL_RESET);
    else if (wr_ctrl) ctrl_q <= ptmr_ctrl_t'(bus_wdata_i);
  end

  always_ff @(posedge clk) begin
    if (rst)                       hbuf_q <= '0;
    else if (wr_hi)                hbuf_q <= bus_wdata_i;
    else if (rd_lo && ctrl_q.wide) hbuf_q <= cnt[CNT_W-1:BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd_i) begin
      case (ptmr_reg_e'(bus_addr_i))
        REG_CTRL: rdata_q <= ctrl_q;
        REG_LOW:  rdata_q <= cnt[BYTE_W-1:0];
        REG_HIGH: rdata_q <= hbuf_q;
        default:  rdata_q <= {{(BYTE_W-1){1'b0}}, flag_o};
      endcase
    end
  end

  assign bus_rdata_o = rdata_q;

  // R7: holding register moves only on its own write or a wide low-byte read
  assert_hbuf_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!wr_hi && !(rd_lo && ctrl_q.wide)) |=> $stable(hbuf_q));
  // R5: disabled counter produces no steps into the count path
  assert_disable_R5: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.en && !wr_lo) |=> $stable(cnt));
endmodule

// File: tb/prescaled_timer_bench.sv
module prescaled_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 1'b0;
  logic       ext_pin_i = 1'b0;
  logic [1:0] bus_addr_i = 2'd0;
  logic       bus_wr_i = 1'b0;
  logic       bus_rd_i = 1'b0;
  logic [7:0] bus_wdata_i = 8'h00;
  logic [7:0] bus_rdata_o;
  logic       flag_o;

  int checks = 0;
  int fails  = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  prescaled_timer u_prescaled_timer (
    .clk(clk), .rst(rst), .tick_i(tick_i), .ext_pin_i(ext_pin_i),
    .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .flag_o(flag_o));

  // {ctrl, preload, ticks, expected low byte}
  localparam logic [31:0] VEC [6] = '{
    {8'h88, 8'h10, 8'd7,  8'h15},  // R2 bypass timer
    {8'h80, 8'h00, 8'd12, 8'h05},  // R4 1:2
    {8'h82, 8'h20, 8'd26, 8'h23},  // R4 1:8
    {8'h08, 8'h33, 8'd10, 8'h33},  // R5 disabled
    {8'h88, 8'hFE, 8'd5,  8'h01},  // R9 wrap in narrow mode
    {8'h81, 8'h40, 8'd14, 8'h43}   // R4 1:4 and R6 hold
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr_i = a; bus_rd_i = 1'b1;
    @(negedge clk);
    bus_rd_i = 1'b0;
    d = bus_rdata_o;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick_i = 1'b1; @(negedge clk);
      tick_i = 1'b0; @(negedge clk);
    end
  endtask

  task automatic pin_pulses(input int n);
    for (int k = 0; k < n; k++) begin
      ext_pin_i = 1'b1; repeat (5) @(negedge clk);
      ext_pin_i = 1'b0; repeat (5) @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: got 0x00 expected 0x01");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 flag", {7'd0, flag_o}, 8'h00);
    rd(2'd0, rv); chk("R1 ctrl", rv, 8'hA7);
    rd(2'd1, rv); chk("R1 low", rv, 8'h00);

    // vector table
    for (int i = 0; i < 6; i++) begin
      wr(2'd0, VEC[i][31:24]);
      wr(2'd1, VEC[i][23:16]);
      ticks(int'(VEC[i][15:8]));
      rd(2'd1, rv);
      chk($sformatf("R2/R4/R5 vector %0d", i), rv, VEC[i][7:0]);
    end
    chk("R9 narrow wrap flag", {7'd0, flag_o}, 8'h01);
    wr(2'd3, 8'h01);
    chk("R10 clear", {7'd0, flag_o}, 8'h00);

    // R6 hold-off exact tick
    wr(2'd0, 8'h88); wr(2'd1, 8'h50);
    ticks(2); rd(2'd1, rv); chk("R6 held two ticks", rv, 8'h50);
    ticks(1); rd(2'd1, rv); chk("R6 resumes third tick", rv, 8'h51);

    // R6 prescaler cleared by low write
    wr(2'd0, 8'h81); wr(2'd1, 8'h00);
    ticks(5);
    wr(2'd1, 8'h00);
    ticks(3); rd(2'd1, rv); chk("R6 prescaler cleared", rv, 8'h00);
    ticks(3); rd(2'd1, rv); chk("R6 fourth event steps", rv, 8'h01);

    // R8 / R7 buffered wide access
    wr(2'd0, 8'hC8);
    wr(2'd2, 8'h12); wr(2'd1, 8'hFF);
    wr(2'd2, 8'h55);
    rd(2'd1, rv); chk("R7 low", rv, 8'hFF);
    rd(2'd2, rv); chk("R8 high write ignored", rv, 8'h12);
    ticks(3);
    rd(2'd1, rv); chk("R7 carry low", rv, 8'h00);
    rd(2'd2, rv); chk("R7 carry high", rv, 8'h13);

    // R9 wide wrap
    wr(2'd2, 8'hFF); wr(2'd1, 8'hFF);
    ticks(2); chk("R9 no early flag", {7'd0, flag_o}, 8'h00);
    ticks(1); chk("R9 wide wrap flag", {7'd0, flag_o}, 8'h01);
    rd(2'd1, rv); rd(2'd2, rv); chk("R9 wide wrap high", rv, 8'h00);
    wr(2'd3, 8'h01);

    // R9 narrow mode keeps upper byte
    wr(2'd2, 8'h34); wr(2'd1, 8'hFF);
    wr(2'd0, 8'h88);
    ticks(3);
    chk("R9 narrow flag", {7'd0, flag_o}, 8'h01);
    wr(2'd0, 8'hC8);
    rd(2'd1, rv); chk("R9 narrow low", rv, 8'h00);
    rd(2'd2, rv); chk("R9 upper untouched", rv, 8'h34);

    // R10 clear collides with overflow
    wr(2'd3, 8'h01);
    wr(2'd0, 8'h88); wr(2'd1, 8'hFF); ticks(2);
    tick_i = 1'b1; bus_addr_i = 2'd3; bus_wdata_i = 8'h01; bus_wr_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0; bus_wr_i = 1'b0;
    chk("R10 overflow beats clear", {7'd0, flag_o}, 8'h01);
    rd(2'd3, rv); chk("R10 flag readback", rv, 8'h01);
    rd(2'd1, rv); chk("R10 count wrapped", rv, 8'h00);
    wr(2'd3, 8'h01);
    chk("R10 later clear", {7'd0, flag_o}, 8'h00);

    // R3 rising edges and synchronizer delay
    wr(2'd0, 8'hA8); wr(2'd1, 8'h00); ticks(2);
    ext_pin_i = 1'b1;
    @(negedge clk);
    rd(2'd1, rv); chk("R3 sync delay", rv, 8'h00);
    repeat (4) @(negedge clk);
    ext_pin_i = 1'b0; repeat (5) @(negedge clk);
    rd(2'd1, rv); chk("R3 one rise", rv, 8'h01);
    pin_pulses(2);
    ticks(4);
    rd(2'd1, rv); chk("R3 rising only, R2 ticks ignored", rv, 8'h03);

    // R3 falling edges
    wr(2'd0, 8'hB8); wr(2'd1, 8'h00); ticks(2);
    pin_pulses(3);
    rd(2'd1, rv); chk("R3 falling", rv, 8'h03);

    // R2 timer mode ignores pin
    wr(2'd0, 8'h88); wr(2'd1, 8'h00); ticks(2);
    pin_pulses(2);
    rd(2'd1, rv); chk("R2 pin ignored", rv, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule